// File: doc/BRIEF.md
# Serial Receiver with Software-Driven Transmit Bit

This block is an 8-bit I/O-bus serial peripheral with an asymmetric design. The receive direction uses a hardware UART receiver. It synchronises the RX line, finds a start edge, checks the start bit at its midpoint and samples eight data bits and one stop bit at their centres, using a 16x oversampling enable. Each good byte is held in a data register, and a ready flag announces it.

The transmit direction has no serialiser. A write to the transmit address copies bit 0 of the bus data into a flop that drives the TX pin directly. Software therefore shapes every start, data and stop bit itself, with its own delays. The TX pin sits high from reset, so the line starts out idle.

The CPU reads two registers and writes one. The receive byte and the transmit bit share one address: a read there returns the byte, and a write there sets the pin. The status register sits at the neighbouring address.

Top module: `sbr_uart_port`

## Requirements
- R1: After reset, tx_pin is 1 and the ready flag is 0, so a status read returns 0x00.
- R2: A write to address 0xF9 sets tx_pin to io_wdata[0] on the following clock. Bits 7..1 of the written value have no effect.
- R3: Writes to any other address, and all reads, leave tx_pin unchanged.
- R4: A read of address 0xF8 returns the ready flag in bit 0 and zeros in bits 7..1.
- R5: An 8N1 frame (low start bit, eight data bits LSB first, high stop bit, each bit 16*OVS_DIV clocks long) sets the ready flag, and a read of 0xF9 then returns the byte.
- R6: A read of 0xF9 clears the ready flag.
- R7: A byte that completes while the ready flag is still set replaces the held byte.
- R8: A frame whose stop bit samples low is dropped. The ready flag and the held byte stay as they were.
- R9: A low pulse on RX shorter than half a bit period is not taken as a start bit, and no byte results.
- R10: io_rdata is 0x00 in every cycle where io_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Serial receive line, asynchronous |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| tx_pin | output | 1 | Transmit line driven by the latched bit |

## Verification
A wrong transmit latch shows on tx_pin one clock after the offending write, or in any cycle with no write in which the pin moves. A receiver that drifts out of phase, or that mishandles the stop bit, shows up only when the CPU next reads status or data. That read comes at least one bit period after the frame ends. A missed read-clear shows on the very next status read.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sbr_ovs_tick.sv
module sbr_ovs_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("sbr_ovs_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_clk
      assign tick = 1'b1;
   end else begin : g_divider
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);
   end
endmodule

// File: rtl/sbr_rx_core.sv
module sbr_rx_core
   import sbr_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   output logic              frame_ok,
   output logic              frame_bad,
   output logic [DATA_W-1:0] byte_o
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("sbr_rx_core: OVS must be even and at least 4");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("sbr_rx_core: DATA_W must be at least 1");
   end

   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

   rx_state_e         st;
   logic [CW-1:0]     tcnt;
   logic [BW-1:0]     bcnt;
   logic [DATA_W-1:0] shreg;
   logic              rx_prev;
   logic              fall;

   assign fall = rx_prev & ~rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         tcnt      <= '0;
         bcnt      <= '0;
         shreg     <= '0;
         rx_prev   <= 1'b1;
         frame_ok  <= 1'b0;
         frame_bad <= 1'b0;
      end else begin
         rx_prev   <= rx;
         frame_ok  <= 1'b0;
         frame_bad <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (fall) begin
                  st   <= RX_START;
                  tcnt <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (tcnt == HALF_LAST) begin
                     tcnt <= '0;
                     bcnt <= '0;
                     st   <= rx ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (tcnt == FULL_LAST) begin
                     tcnt <= '0;
                     if (DATA_W > 1) shreg <= {rx, shreg[DATA_W-1:1]};
                     else            shreg <= rx;
                     if (bcnt == BIT_LAST) st <= RX_STOP;
                     else                  bcnt <= bcnt + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (tcnt == FULL_LAST) begin
                     tcnt      <= '0;
                     st        <= RX_IDLE;
                     frame_ok  <= rx;
                     frame_bad <= ~rx;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assign byte_o = shreg;
endmodule

// File: rtl/sbr_uart_port.sv
module sbr_uart_port #(
   parameter int unsigned          ADDR_W      = 8,
   parameter int unsigned          DATA_W      = 8,
   parameter logic [ADDR_W-1:0]    STAT_ADDR   = 8'hF8,
   parameter logic [ADDR_W-1:0]    DATA_ADDR   = 8'hF9,
   parameter int unsigned          OVS         = 16,
   parameter int unsigned          OVS_DIV     = 4,
   parameter int unsigned          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_pin,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [DATA_W-1:0] io_rdata,
   output logic              tx_pin
);
   if (STAT_ADDR == DATA_ADDR) begin : g_bad_map
      $error("sbr_uart_port: status and data addresses must differ");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("sbr_uart_port: DATA_W must be at least 2");
   end

   logic              rx_s;
   logic              tick;
   logic              frame_ok;
   logic              frame_bad;
   logic [DATA_W-1:0] rx_byte;
   logic [DATA_W-1:0] held;
   logic              rx_ready;
   logic              tx_q;
   logic              hit_data_rd;
   logic              hit_stat_rd;
   logic              hit_tx_wr;

   sbr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s)
   );

   sbr_ovs_tick #(.DIV(OVS_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   sbr_rx_core #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
      .frame_ok(frame_ok), .frame_bad(frame_bad), .byte_o(rx_byte)
   );

   assign hit_data_rd = io_rd && (io_addr == DATA_ADDR);
   assign hit_stat_rd = io_rd && (io_addr == STAT_ADDR);
   assign hit_tx_wr   = io_wr && (io_addr == DATA_ADDR);

   // Held byte and ready flag: a completing byte wins over a same-cycle read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= '0;
         rx_ready <= 1'b0;
      end else if (frame_ok) begin
         held     <= rx_byte;
         rx_ready <= 1'b1;
      end else if (hit_data_rd) begin
         rx_ready <= 1'b0;
      end
   end

   // Transmit bit latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tx_q <= 1'b1;
      else if (hit_tx_wr) tx_q <= io_wdata[0];
   end

   assign tx_pin = tx_q;

   always_comb begin
      io_rdata = '0;
      if (hit_data_rd)      io_rdata = held;
      else if (hit_stat_rd) io_rdata = {{(DATA_W-1){1'b0}}, rx_ready};
   end
endmodule

// File: rtl/sbr_uart_chk.sv
module sbr_uart_chk #(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hF9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_rdata,
   input logic              tx_pin,
   input logic              rx_ready,
   input logic              frame_ok,
   input logic              frame_bad,
   input logic [DATA_W-1:0] held
);
   // R2
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == DATA_ADDR) |=> (tx_pin == $past(io_wdata[0])));

   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == DATA_ADDR) |=> $stable(tx_pin));

   // R4
   stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == STAT_ADDR) |-> (io_rdata[DATA_W-1:1] == '0));

   // R5
   ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> rx_ready);

   // R6
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == DATA_ADDR && !frame_ok) |=> !rx_ready);

   // R8
   bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bad && !(io_rd && io_addr == DATA_ADDR)) |=> ($stable(held) && $stable(rx_ready)));

   // R8
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok && frame_bad));

   // R10
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '0));
endmodule

bind sbr_uart_port sbr_uart_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
   .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .tx_pin(tx_pin),
   .rx_ready(rx_ready), .frame_ok(frame_ok), .frame_bad(frame_bad), .held(held)
);

// File: tb/sbr_uart_port_tb.sv
module sbr_uart_port_tb;
   localparam int OVS_DIV = 4;
   localparam int BIT_CLK = 16 * OVS_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_pin = 1'b1;
   logic [7:0] io_addr = '0;
   logic [7:0] io_wdata = '0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [7:0] io_rdata;
   logic       tx_pin;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   // reference model state
   bit       m_tx = 1'b1;
   bit       m_ready = 1'b0;
   bit [7:0] m_data = 8'h00;

   always #2.5 clk = ~clk;

   sbr_uart_port #(.OVS_DIV(OVS_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
      .io_rdata(io_rdata), .tx_pin(tx_pin)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(posedge clk) begin
      #2;
      if (cmp_en) begin
         chk("R2/R3 tx_pin vs model", {7'b0, tx_pin}, {7'b0, m_tx});
         if (!io_rd) chk("R10 idle read bus", io_rdata, 8'h00);
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk);
      if (a == 8'hF9) m_tx = d[0];
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(posedge clk);
      if (a == 8'hF9) m_ready = 1'b0;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      @(negedge clk);
      rx_pin = 1'b0;
      repeat (BIT_CLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_pin = b[i];
         repeat (BIT_CLK) @(negedge clk);
      end
      rx_pin = stop;
      repeat (BIT_CLK) @(negedge clk);
      rx_pin = 1'b1;
      repeat (BIT_CLK) @(negedge clk);
      if (stop) begin
         m_ready = 1'b1;
         m_data  = b;
      end
   endtask

   task automatic expect_status(input string tag);
      logic [7:0] v;
      bus_read(8'hF8, v);
      chk(tag, v, {7'b0, m_ready});
   endtask

   task automatic expect_data(input string tag);
      logic [7:0] v;
      bus_read(8'hF9, v);
      chk(tag, v, m_data);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R1 reset state
      chk("R1 tx_pin after reset", {7'b0, tx_pin}, 8'h01);
      expect_status("R1 status after reset");

      // R2 transmit bit follows bit 0 only
      bus_write(8'hF9, 8'hFE);
      chk("R2 tx low from 0xFE", {7'b0, tx_pin}, 8'h00);
      bus_write(8'hF9, 8'h01);
      chk("R2 tx high from 0x01", {7'b0, tx_pin}, 8'h01);
      bus_write(8'hF9, 8'hAA);
      chk("R2 tx low from 0xAA", {7'b0, tx_pin}, 8'h00);

      // R3 other accesses leave tx alone
      bus_write(8'hF8, 8'hFF);
      chk("R3 write to status addr", {7'b0, tx_pin}, 8'h00);
      bus_write(8'h10, 8'h01);
      chk("R3 write to other addr", {7'b0, tx_pin}, 8'h00);
      bus_read(8'hF9, v);
      chk("R3 read of data addr", {7'b0, tx_pin}, 8'h00);
      bus_write(8'hF9, 8'h01);

      // R5 R4 reception of several patterns
      send_frame(8'hA5, 1'b1);
      expect_status("R4 R5 status after 0xA5");
      expect_data("R5 data 0xA5");
      expect_status("R6 status after data read");
      send_frame(8'h00, 1'b1);
      expect_status("R4 status after 0x00");
      expect_data("R5 data 0x00");
      send_frame(8'hFF, 1'b1);
      expect_data("R5 data 0xFF");
      expect_status("R6 cleared after 0xFF read");

      // R7 overwrite while ready
      send_frame(8'h3C, 1'b1);
      send_frame(8'hC3, 1'b1);
      expect_status("R7 ready still set");
      expect_data("R7 newer byte kept");

      // R8 stop bit low: dropped
      send_frame(8'h5A, 1'b0);
      expect_status("R8 no ready after bad stop");
      expect_data("R8 held byte unchanged");

      // R9 short low glitch rejected
      @(negedge clk);
      rx_pin = 1'b0;
      repeat (10) @(negedge clk);
      rx_pin = 1'b1;
      repeat (3 * BIT_CLK) @(negedge clk);
      expect_status("R9 glitch gives no byte");

      // R5 receiver still works after glitch and bad frame
      send_frame(8'h69, 1'b1);
      expect_data("R5 data 0x69 after errors");

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule